// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block decides when a DRAM row must be refreshed and which row it is. It keeps a retention-window timer, an interval timer, a row pointer and a backlog of refreshes that are owed but not yet done. It raises a request that carries the current row number. The memory access controller answers with a one-cycle acknowledge when it has started the row activate-and-restore. Carrying out the refresh is the controller's job.

Two schedules are supported. In spread mode one refresh is owed per interval, where the interval is the window length divided by the row count. In burst mode every row is owed at once at the start of a window, and the rows are then served back to back. The mode input is captured only when a window begins. A switch between modes therefore never leaves a row without its refresh in the window. After each acknowledge the request is held low for the row busy time. When the backlog is too deep to accept another refresh, the excess is dropped and a sticky overflow flag is raised.

The parameters are the clock frequency in MHz, the row count, the window length in ns, the per-row busy time in ns and the backlog limit. All cycle counts are derived from these parameters.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted and directly after it, req_o is 0, row_o is 0, backlog_o is 0 and overflow_o is 0.
- R2: In spread mode the backlog grows by one at the end of every interval of INT_CYC = floor(WIN_CYC / ROWS) cycles, where WIN_CYC = floor(WINDOW_NS * CLK_MHZ / 1000). The interval timer restarts at each window start, so the first refresh is owed INT_CYC cycles after reset release.
- R3: req_o is 1 exactly when the backlog is nonzero and no busy gap is running. Once raised, it stays at 1 until it is acknowledged.
- R4: row_o advances by one on every acknowledged request (req_o and ack_i both 1 at a clock edge) and wraps from ROWS-1 to 0.
- R5: After each acknowledged request, req_o stays at 0 for BUSY_CYC = ceil(BUSY_NS * CLK_MHZ / 1000) cycles. Consecutive burst grants are therefore BUSY_CYC+1 cycles apart.
- R6: If refreshes are owed while the backlog left after this cycle's acknowledge is already PEND_MAX or more, the new refreshes are dropped and overflow_o is set. overflow_o stays set until reset.
- R7: A window starts at the first clock edge after reset release and then every WIN_CYC cycles. burst_mode_i (1 = burst, 0 = spread) is captured only at a window start, so a change in mid-window has no effect until the next start.
- R8: At the start of a window captured in burst mode, ROWS refreshes are added to the backlog. Interval ends are ignored for the whole of that window.
- R9: An ack_i pulse while req_o is 0 changes neither row_o nor backlog_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| burst_mode_i | input | 1 | Schedule select, 1 = burst, 0 = spread; captured at window start |
| ack_i | input | 1 | Controller has taken the current refresh request |
| req_o | output | 1 | Refresh request |
| row_o | output | $clog2(ROWS) | Row to refresh |
| backlog_o | output | $clog2(ROWS+PEND_MAX+1) | Refreshes owed, including the one requested |
| overflow_o | output | 1 | Sticky: an owed refresh was dropped |

## Verification
The bench pins down when the first interval ends and checks the request one cycle before and one cycle after that edge. An off-by-one in the timer or in the interval restart would show up at exactly those cycles. It lets the backlog grow to the limit and checks that the next owed refresh is dropped and flagged rather than counted. It also checks that the flag survives a later clean window. The mode input is flipped in mid-window, and the bench confirms that spread ticks keep arriving until the window boundary and that a burst then adds all rows on top of a leftover spread refresh. A design that sampled the mode at once would skip or duplicate rows. The burst drain checks the wrapped row sequence and the exact gap between grants, and a stray acknowledge with no request must leave the row and the backlog unchanged.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic {
    MODE_SPREAD = 1'b0,
    MODE_BURST  = 1'b1
  } rfs_mode_e;

  // nanoseconds to clock cycles, either truncated or rounded up
  function automatic longint ns_to_cyc(longint ns, longint mhz, bit round_up);
    longint prod;
    prod = ns * mhz;
    if (round_up) return (prod + 64'd999) / 64'd1000;
    return prod / 64'd1000;
  endfunction

endpackage

// File: rtl/rfs_timebase.sv
module rfs_timebase #(
  parameter int WIN_CYC = 400,
  parameter int INT_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic win_start_o,
  output logic tick_o
);
  localparam int WW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam int IW = (INT_CYC > 1) ? $clog2(INT_CYC) : 1;
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_CYC - 1);
  localparam logic [IW-1:0] INT_LAST = IW'(INT_CYC - 1);

  logic [WW-1:0] win_q, win_n;
  logic [IW-1:0] int_q, int_n;
  logic          win_end;

  assign win_end     = (win_q == WIN_LAST);
  assign win_start_o = (win_q == '0);
  assign tick_o      = (int_q == INT_LAST);

  always_comb begin
    win_n = win_end ? '0 : win_q + WW'(1);
    int_n = (tick_o || win_end) ? '0 : int_q + IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      int_q <= '0;
    end else begin
      win_q <= win_n;
      int_q <= int_n;
    end
  end

  // R2
  interval_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (int_q == '0) && win_start_o);

endmodule

// File: rtl/rfs_backlog.sv
module rfs_backlog #(
  parameter int ROWS     = 8192,
  parameter int PEND_MAX = 4,
  parameter int BUSY_CYC = 6
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                ack_i,
  input  logic                                add_i,
  input  logic                                add_all_i,
  output logic                                req_o,
  output logic                                take_o,
  output logic [$clog2(ROWS+PEND_MAX+1)-1:0]  owed_o,
  output logic                                ovf_o
);
  localparam int OW = $clog2(ROWS + PEND_MAX + 1);
  localparam int GW = $clog2(BUSY_CYC + 1) > 0 ? $clog2(BUSY_CYC + 1) : 1;
  localparam logic [OW-1:0] LIMIT    = OW'(PEND_MAX);
  localparam logic [OW-1:0] ALL_ROWS = OW'(ROWS);
  localparam logic [GW-1:0] GAP_LOAD = GW'(BUSY_CYC);

  logic [OW-1:0] owed_q, owed_n, remain;
  logic [GW-1:0] gap_q, gap_n;
  logic          ovf_q, ovf_n;

  assign req_o  = (owed_q != '0) && (gap_q == '0);
  assign take_o = req_o && ack_i;
  assign owed_o = owed_q;
  assign ovf_o  = ovf_q;
  assign remain = owed_q - OW'(take_o);

  always_comb begin
    owed_n = remain;
    ovf_n  = ovf_q;
    if (add_i) begin
      if (remain >= LIMIT) ovf_n = 1'b1;
      else owed_n = remain + (add_all_i ? ALL_ROWS : OW'(1));
    end
  end

  always_comb begin
    gap_n = gap_q;
    if (take_o)            gap_n = GAP_LOAD;
    else if (gap_q != '0)  gap_n = gap_q - GW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed_q <= '0;
      gap_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      owed_q <= owed_n;
      gap_q  <= gap_n;
      ovf_q  <= ovf_n;
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && !ack_i |=> req_o);

  // R5
  busy_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (BUSY_CYC > 0) && take_o |=> !req_o);

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);

  // R6
  backlog_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q <= OW'(ROWS + PEND_MAX - 1));

endmodule

// File: rtl/rfs_row_ctr.sv
module rfs_row_ctr #(
  parameter int ROWS = 8192
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step_i,
  output logic [$clog2(ROWS)-1:0] row_o
);
  localparam int RW = $clog2(ROWS);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);

  logic [RW-1:0] row_q, row_n;

  assign row_o = row_q;

  always_comb begin
    row_n = row_q;
    if (step_i) row_n = (row_q == ROW_LAST) ? '0 : row_q + RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else        row_q <= row_n;
  end

  // R4
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> row_q != $past(row_q));

  // R9
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(row_q));

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int CLK_MHZ   = 200,
  parameter int ROWS      = 8192,
  parameter int WINDOW_NS = 64_000_000,
  parameter int BUSY_NS   = 30,
  parameter int PEND_MAX  = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                burst_mode_i,
  input  logic                                ack_i,
  output logic                                req_o,
  output logic [$clog2(ROWS)-1:0]             row_o,
  output logic [$clog2(ROWS+PEND_MAX+1)-1:0]  backlog_o,
  output logic                                overflow_o
);
  import rfs_pkg::*;

  localparam int WIN_CYC  = int'(ns_to_cyc(longint'(WINDOW_NS), longint'(CLK_MHZ), 1'b0));
  localparam int INT_CYC  = WIN_CYC / ROWS;
  localparam int BUSY_CYC = int'(ns_to_cyc(longint'(BUSY_NS), longint'(CLK_MHZ), 1'b1));

  rfs_mode_e mode_q, mode_n;
  logic      win_start, tick, take, add, add_all;

  rfs_timebase #(.WIN_CYC(WIN_CYC), .INT_CYC(INT_CYC)) u_time (
    .clk        (clk),
    .rst_n      (rst_n),
    .win_start_o(win_start),
    .tick_o     (tick)
  );

  // burst add uses the mode being captured this edge; ticks use the held mode
  always_comb begin
    mode_n  = mode_q;
    if (win_start) mode_n = burst_mode_i ? MODE_BURST : MODE_SPREAD;
    add_all = win_start && burst_mode_i;
    add     = add_all || (tick && (mode_q == MODE_SPREAD));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_SPREAD;
    else        mode_q <= mode_n;
  end

  rfs_backlog #(.ROWS(ROWS), .PEND_MAX(PEND_MAX), .BUSY_CYC(BUSY_CYC)) u_backlog (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_i    (ack_i),
    .add_i    (add),
    .add_all_i(add_all),
    .req_o    (req_o),
    .take_o   (take),
    .owed_o   (backlog_o),
    .ovf_o    (overflow_o)
  );

  rfs_row_ctr #(.ROWS(ROWS)) u_row (
    .clk   (clk),
    .rst_n (rst_n),
    .step_i(take),
    .row_o (row_o)
  );

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_start |=> mode_q == $past(mode_q));

  // R8
  burst_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_BURST) && !win_start && !take |=> backlog_o == $past(backlog_o));

endmodule

// File: tb/refresh_sched_tb.sv
`timescale 1ns/1ps
module refresh_sched_tb;
  localparam int ROWS = 8;
  localparam int PMAX = 3;
  localparam int INTV = 50;
  localparam int BUSY = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       burst = 1'b0;
  logic       ack = 1'b0;
  logic       req;
  logic [2:0] row;
  logic [3:0] backlog;
  logic       ovf;
  int         cyc;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;

  refresh_sched #(
    .CLK_MHZ(200), .ROWS(ROWS), .WINDOW_NS(2000), .BUSY_NS(30), .PEND_MAX(PMAX)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .burst_mode_i(burst), .ack_i(ack),
    .req_o(req), .row_o(row), .backlog_o(backlog), .overflow_o(ovf)
  );

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic at(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 req", req, 0);
    check("R1 row", row, 0);
    check("R1 backlog", backlog, 0);
    check("R1 overflow", ovf, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_spread();
    at(INTV - 1);
    check("R2 no req before interval", req, 0);
    at(INTV);
    check("R2 req after interval", req, 1);
    check("R2 backlog", backlog, 1);
    at(INTV + 5);
    check("R3 req held", req, 1);
    check("R4 row before ack", row, 0);
    pulse_ack();
    check("R4 row after ack", row, 1);
    check("R3 req dropped", req, 0);
    check("R2 backlog after ack", backlog, 0);
  endtask

  task automatic t_gap();
    at(2 * INTV - 1);
    check("R2 backlog", backlog, 0);
    at(3 * INTV);
    check("R2 two owed", backlog, 2);
    pulse_ack();
    check("R5 gap start", req, 0);
    check("R4 row", row, 2);
    at(3 * INTV + BUSY);
    check("R5 gap end", req, 0);
    at(3 * INTV + BUSY + 1);
    check("R5 req back", req, 1);
  endtask

  task automatic t_overflow();
    at(5 * INTV);
    check("R6 backlog at limit", backlog, 3);
    check("R6 no overflow yet", ovf, 0);
    at(6 * INTV);
    check("R6 dropped", backlog, 3);
    check("R6 overflow set", ovf, 1);
  endtask

  task automatic t_mode();
    int prev;
    prev = 0;
    for (int i = 0; i < 3; i++) begin
      while (!req) @(negedge clk);
      if (i > 0) check("R5 drain spacing", cyc - prev, BUSY + 1);
      prev = cyc;
      pulse_ack();
    end
    check("R4 row after drain", row, 5);
    check("R3 backlog empty", backlog, 0);
    at(320);
    burst = 1'b1;
    at(7 * INTV);
    check("R7 mid-window change ignored", backlog, 1);
    pulse_ack();
    check("R4 row", row, 6);
    at(8 * INTV);
    check("R7 last spread tick", backlog, 1);
  endtask

  task automatic t_burst();
    int prev;
    prev = 0;
    at(401);
    check("R8 burst added", backlog, 9);
    for (int i = 0; i < 9; i++) begin
      while (!req) @(negedge clk);
      check("R4 burst row", row, (6 + i) % ROWS);
      if (i > 0) check("R5 burst spacing", cyc - prev, BUSY + 1);
      prev = cyc;
      pulse_ack();
    end
    check("R4 wrapped row", row, 7);
    check("R8 burst drained", backlog, 0);
  endtask

  task automatic t_ignored();
    at(470);
    check("R9 req low", req, 0);
    pulse_ack();
    check("R9 row unchanged", row, 7);
    check("R9 backlog unchanged", backlog, 0);
  endtask

  task automatic t_back_to_spread();
    at(700);
    burst = 1'b0;
    at(799);
    check("R8 ticks ignored in burst window", backlog, 0);
    at(801);
    check("R7 no burst after spread captured", backlog, 0);
    at(849);
    check("R2 none before interval", backlog, 0);
    at(850);
    check("R2 spread resumes", backlog, 1);
    check("R6 overflow sticky", ovf, 1);
  endtask

  initial begin
    t_reset();
    t_spread();
    t_gap();
    t_overflow();
    t_mode();
    t_burst();
    t_ignored();
    t_back_to_spread();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog cyc=%0d actual=hung expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule